// File: doc/BRIEF.md
# Variable-Latency Row Refresh Engine

This block serves refresh requests for one DRAM bank and decides, row by row, how long each refresh takes. A short partial refresh is used by default. It keeps the bank busy for 60% of the nominal refresh time and leaves the cells slightly under full charge. A row tolerates only a limited run of such partial refreshes, and the length of that run differs from row to row. The engine therefore stores a per-row limit, which software or a profiler loads through a write port. It also counts the partial refreshes each row has had since its last full refresh. When a row's count reaches its limit, the next refresh of that row is a full refresh at nominal latency, and the count starts again from zero.

Refresh requests are single-cycle pulses that carry a row number. While the bank is busy, one request can wait in a single pending slot. Neither the request input nor the limit write port has back-pressure. A limit write is always accepted in the cycle it is presented. A request that finds both the bank busy and the slot occupied is discarded, and the overflow pin pulses. The outputs show whether a refresh is in progress, whether it is a full or a partial refresh, and the last cycle of that refresh.

Top module: `refresh_engine`

## Requirements
- R1: After reset, busy_o, done_o and ovf_o are 0, and every stored limit and partial count is 0.
- R2: The first refresh of any row after reset is a full refresh (full_o = 1), whatever limit has been loaded.
- R3: A full refresh holds busy_o high for exactly NOM_LAT cycles (default 10). A partial refresh holds it for PART_LAT = ceil(0.6 x NOM_LAT) cycles (default 6). busy_o rises in the cycle after the launching clock edge.
- R4: A row whose partial count is below its limit receives a partial refresh (full_o = 0), and its count increments by 1. When the count is equal to or greater than the limit, the row receives a full refresh and its count returns to 0. So a limit of L gives the repeating pattern: one full refresh followed by L partial refreshes.
- R5: A row with a stored limit of 0 receives a full refresh on every request.
- R6: done_o is high for exactly one cycle, which is the last cycle of busy_o. full_o stays constant for the whole busy period.
- R7: A request that arrives while busy_o is high is held in the pending slot. That request launches at the second clock edge after busy_o falls, so there is one idle cycle between the two busy periods.
- R8: A request that arrives while busy_o is high and the slot is already occupied is discarded. ovf_o pulses high in the following cycle, and the discarded request leaves its row's count unchanged.
- R9: A limit write (lim_we_i) changes only that row's limit and never its count. It applies to refreshes that launch after the write edge.
- R10: Rows are independent. Refreshing one row or writing its limit does not change the refresh type chosen for any other row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Refresh request pulse |
| req_row_i | input | ROW_W | Row to refresh |
| lim_we_i | input | 1 | Limit write strobe |
| lim_row_i | input | ROW_W | Row whose limit is written |
| lim_val_i | input | LIM_W | Maximum consecutive partial refreshes |
| busy_o | output | 1 | Bank occupied by a refresh |
| full_o | output | 1 | 1 = full refresh, 0 = partial (valid while busy) |
| done_o | output | 1 | Last busy cycle of a refresh |
| ovf_o | output | 1 | Pulse: a request was discarded |

## Verification
Every cycle, the assertions check the shape of each busy period. They confirm that its length matches the full or partial latency (R3), that done_o marks only its final cycle, and that full_o holds steady across it (R6). They also confirm that an overflow pulse follows a request made while the bank was busy (R8). The choice between partial and full refresh depends on the limits and counts stored for each row. The bench therefore covers it through scenarios measured against a reference model of those counts. These scenarios include zero limits, lowered limits, a first refresh after reset, the pending-slot timing and a discarded request.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  function automatic int part_latency(input int nominal);
    return (nominal * 6 + 9) / 10;
  endfunction
endpackage

// File: rtl/refresh_row_table.sv
module refresh_row_table #(
  parameter int ROWS  = 16,
  parameter int LIM_W = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [LIM_W-1:0] wr_lim_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic             rd_full_o,
  input  logic             upd_en_i,
  input  logic [ROW_W-1:0] upd_row_i,
  input  logic             upd_full_i
);
  logic [ROWS-1:0] want_full;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [LIM_W-1:0] lim_q;
    logic [LIM_W-1:0] cnt_q;
    logic             seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lim_q  <= '0;
        cnt_q  <= '0;
        seen_q <= 1'b0;
      end else begin
        if (wr_en_i && wr_row_i == ROW_W'(g)) lim_q <= wr_lim_i;
        if (upd_en_i && upd_row_i == ROW_W'(g)) begin
          seen_q <= 1'b1;
          cnt_q  <= upd_full_i ? '0 : cnt_q + 1'b1;
        end
      end
    end

    assign want_full[g] = !seen_q || (cnt_q >= lim_q);
  end

  assign rd_full_o = want_full[rd_row_i];
endmodule

// File: rtl/refresh_req_slot.sv
module refresh_req_slot #(
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             req_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             launch_o,
  output logic [ROW_W-1:0] launch_row_o,
  output logic             ovf_o
);
  logic             pend_q;
  logic [ROW_W-1:0] pend_row_q;
  logic             ovf_q;
  logic             drain, direct, to_slot, slot_free;

  assign drain     = idle_i && pend_q;
  assign direct    = idle_i && !pend_q && req_i;
  assign to_slot   = req_i && !direct;
  assign slot_free = !pend_q || drain;

  assign launch_o     = drain || direct;
  assign launch_row_o = pend_q ? pend_row_q : req_row_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_row_q <= '0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_q <= to_slot && !slot_free;
      if (to_slot && slot_free) begin
        pend_q     <= 1'b1;
        pend_row_q <= req_row_i;
      end else if (drain) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/refresh_lat_timer.sv
module refresh_lat_timer #(
  parameter int NOM_LAT  = 10,
  parameter int PART_LAT = 6,
  localparam int LAT_W = $clog2(NOM_LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_full_i,
  output logic idle_o,
  output logic busy_o,
  output logic full_o,
  output logic done_o
);
  logic [LAT_W-1:0] rem_q;
  logic             full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      full_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= start_full_i ? LAT_W'(NOM_LAT) : LAT_W'(PART_LAT);
      full_q <= start_full_i;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign idle_o = (rem_q == '0);
  assign busy_o = !idle_o;
  assign done_o = (rem_q == LAT_W'(1));
  assign full_o = full_q;
endmodule

// File: rtl/refresh_engine.sv
module refresh_engine #(
  parameter int ROWS    = 16,
  parameter int LIM_W   = 4,
  parameter int NOM_LAT = 10,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int PART_LAT = refresh_pkg::part_latency(NOM_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic             lim_we_i,
  input  logic [ROW_W-1:0] lim_row_i,
  input  logic [LIM_W-1:0] lim_val_i,
  output logic             busy_o,
  output logic             full_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic             idle, launch, launch_full;
  logic [ROW_W-1:0] launch_row;

  refresh_req_slot #(.ROW_W(ROW_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle),
    .req_i(req_i), .req_row_i(req_row_i),
    .launch_o(launch), .launch_row_o(launch_row), .ovf_o(ovf_o)
  );

  refresh_row_table #(.ROWS(ROWS), .LIM_W(LIM_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(lim_we_i), .wr_row_i(lim_row_i), .wr_lim_i(lim_val_i),
    .rd_row_i(launch_row), .rd_full_o(launch_full),
    .upd_en_i(launch), .upd_row_i(launch_row), .upd_full_i(launch_full)
  );

  refresh_lat_timer #(.NOM_LAT(NOM_LAT), .PART_LAT(PART_LAT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(launch), .start_full_i(launch_full),
    .idle_o(idle), .busy_o(busy_o), .full_o(full_o), .done_o(done_o)
  );
endmodule

// File: rtl/refresh_engine_chk.sv
module refresh_engine_chk #(
  parameter int NOM_LAT  = 10,
  parameter int PART_LAT = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_o,
  input logic full_o,
  input logic done_o,
  input logic ovf_o
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else run_len <= 0;
  end

  // R3: each busy period ends after the latency of its refresh type
  a_r3_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == ($past(full_o) ? NOM_LAT : PART_LAT)));
  // R3: no busy period outlasts the nominal latency
  a_r3_run_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_len < NOM_LAT));
  // R6: done only inside a busy period
  a_r6_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R6: done marks the final busy cycle
  a_r6_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R6: refresh type steady during a busy period
  a_r6_type_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(full_o));
  // R8: overflow follows a request made while busy
  a_r8_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(req_i) && $past(busy_o)));
endmodule

bind refresh_engine refresh_engine_chk #(.NOM_LAT(NOM_LAT), .PART_LAT(PART_LAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .full_o(full_o), .done_o(done_o), .ovf_o(ovf_o)
);

// File: tb/test_refresh_engine.sv
`timescale 1ns/1ps
module test_refresh_engine;
  localparam int ROWS = 16, LIM_W = 4, NOM = 10, PART = 6, ROW_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ROW_W-1:0] req_row = '0, wr_row = '0;
  logic [LIM_W-1:0] wr_val = '0;
  logic busy, full, done, ovf;

  int total = 0, bad = 0;
  int m_cnt [ROWS];
  int m_lim [ROWS];
  bit m_seen[ROWS];

  always #2.5 clk = ~clk;

  refresh_engine #(.ROWS(ROWS), .LIM_W(LIM_W), .NOM_LAT(NOM)) i_refresh_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_row_i(req_row),
    .lim_we_i(we), .lim_row_i(wr_row), .lim_val_i(wr_val),
    .busy_o(busy), .full_o(full), .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_full(input int r);
    return !m_seen[r] || (m_cnt[r] >= m_lim[r]);
  endfunction

  function automatic void model_launch(input int r);
    bit f = exp_full(r);
    m_seen[r] = 1'b1;
    m_cnt[r]  = f ? 0 : m_cnt[r] + 1;
  endfunction

  task automatic write_lim(input int r, input int v);
    @(negedge clk); we = 1'b1; wr_row = ROW_W'(r); wr_val = LIM_W'(v);
    @(negedge clk); we = 1'b0;
    m_lim[r] = v;
  endtask

  // called at a negedge where busy is already high; measures the run
  task automatic measure(input string tag, input bit ef);
    int n = 0, dpos = -1, dcnt = 0;
    bit f0 = full;
    chk(full == ef, {tag, " type"}, full, ef);
    while (busy && n < 50) begin
      if (full != f0) chk(0, {tag, " R6 type changed"}, full, f0);
      if (done) begin dpos = n; dcnt++; end
      n++;
      @(negedge clk);
    end
    chk(n == (ef ? NOM : PART), {tag, " R3 busy length"}, n, ef ? NOM : PART);
    chk(dcnt == 1 && dpos == n - 1, {tag, " R6 done position"}, dpos, n - 1);
  endtask

  task automatic refresh(input int r, input string tag);
    bit ef = exp_full(r);
    @(negedge clk); req = 1'b1; req_row = ROW_W'(r);
    @(negedge clk); req = 1'b0;
    model_launch(r);
    chk(busy == 1'b1, {tag, " R3 busy rises"}, busy, 1);
    measure(tag, ef);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < ROWS; i++) begin m_cnt[i] = 0; m_lim[i] = 0; m_seen[i] = 0; end
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ovf, "R1 reset outputs", {busy, done, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", busy, 0);

    // R2: first refresh is full even with a limit loaded
    write_lim(3, 2);
    refresh(3, "R2 first refresh");
    // R4: limit 2 -> full, partial, partial, full
    refresh(3, "R4 partial 1");
    refresh(3, "R4 partial 2");
    refresh(3, "R4 full at limit");
    // R5: limit 0 always full
    refresh(5, "R5 first");
    refresh(5, "R5 again");
    refresh(5, "R5 third");
    // R9: raise/lower limit, count preserved
    write_lim(7, 3);
    refresh(7, "R9 init full");
    refresh(7, "R9 partial cnt1");
    write_lim(7, 2);
    refresh(7, "R9 partial cnt2");
    refresh(7, "R9 full at new limit");
    write_lim(7, 1);
    refresh(7, "R9 partial after full");
    write_lim(7, 0);
    refresh(7, "R9 lowered limit forces full");
    // R10: other row untouched
    refresh(3, "R10 row3 partial independent");

    // R7 / R8: pending slot and overflow
    write_lim(9, 4);
    write_lim(10, 4);
    refresh(9, "R7 prep row9");
    @(negedge clk); req = 1'b1; req_row = 4'd8;
    @(negedge clk); req_row = 4'd9;            // held in slot
    @(negedge clk); req_row = 4'd10;           // discarded
    @(negedge clk); req = 1'b0;
    chk(ovf == 1'b1, "R8 ovf pulse", ovf, 1);
    model_launch(8);
    begin
      bit ef8 = 1'b1;
      int guard = 0;
      bit ef9;
      @(negedge clk);
      chk(ovf == 1'b0, "R8 ovf single cycle", ovf, 0);
      while (busy && guard < 50) begin guard++; @(negedge clk); end
      chk(ef8 == 1'b1 && !busy, "R7 gap cycle idle", busy, 0);
      ef9 = exp_full(9);
      @(negedge clk);
      chk(busy == 1'b1, "R7 pending launches after gap", busy, 1);
      model_launch(9);
      measure("R7 pending row9", ef9);
    end
    refresh(10, "R8 dropped row first refresh full");
    refresh(10, "R8 dropped row then partial");

    // random phase
    for (int k = 0; k < 120; k++) begin
      int r = $urandom_range(ROWS - 1);
      if ($urandom_range(3) == 0) write_lim($urandom_range(ROWS - 1), $urandom_range(3));
      refresh(r, "R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule